// File: doc/BRIEF.md
# Drift-Tracking Touch Detector

This block makes the touch decision for one capacitive sense channel. It receives filtered measurement samples, each marked by a one-cycle valid strobe. A finger on the electrode lowers the measured level. The block therefore keeps a no-touch reference and compares the drop below that reference against a touch level and a separate release level. Together these two levels give hysteresis. Separate touch and release debounce counts settle the reported state.

While the channel is released, the reference creeps toward the measurement, one code at a time. Upward and downward creep have independent rates, so a slowly approaching finger is not absorbed into the reference. While the channel is touched, the reference is frozen. The first sample after enable seeds the reference, either from a loaded value or from a chosen fraction of that sample.

For several channels, instantiate one copy per channel. Configuration is captured only while the channel is disabled, so software changes the setup between runs.

Top module: `touch_drift_detector`

## Requirements
- R1: In the released state, a sample is judged touched when `ref - sample` is greater than or equal to the effective touch level; otherwise it is judged released.
- R2: Each level is a 7-bit code plus a times-eight flag. The effective level is the code itself when the flag is 0, and the code shifted left by 3 when the flag is 1.
- R3: While the debounced state is touched, the reference does not change on any sample.
- R4: While released, the reference rises by 1 when the number of consecutive samples above it reaches the up-rate plus one. It falls by 1 when the number of consecutive samples below it reaches the down-rate plus one. A sample equal to the reference, a sample on the other side, or a touched state clears the run count.
- R5: The first valid sample after enable seeds the reference and is not judged. Seed mode 00 loads the user reference value. Mode 01 copies the sample. Mode 10 gives floor(sample*31/32). Mode 11 gives floor(sample*30/32). For that first sample, drop and raw judgement read 0.
- R6: In the touched state, a sample is judged released when `ref - sample` is below the effective release level; otherwise it is judged touched.
- R7: The debounced state flips to touched on the (N+1)-th consecutive touch judgement and back to released on the (M+1)-th consecutive release judgement, where N is the touch count and M is the release count, each 0 to 15. An agreeing judgement clears the count.
- R8: The drop output is `ref - sample`, saturated at 0 when the sample exceeds the reference. The drop and the raw judgement appear on the clock edge that accepts the sample.
- R9: Levels, rates, debounce counts, seed mode and user reference are captured only while `enable` is low. Changes while enabled have no effect. With `enable` low, all outputs read 0, and the next enable re-seeds.
- R10: Clock cycles without a valid strobe leave the outputs and the reference unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel run enable; low loads configuration |
| sample_valid | input | 1 | One-cycle strobe marking a new sample |
| sample | input | 10 | Filtered measurement |
| seed_mode | input | 2 | Initial reference source (R5) |
| user_ref | input | 10 | Loaded initial reference for seed mode 00 |
| touch_thr | input | 7 | Touch level code |
| touch_x8 | input | 1 | Touch level times-eight flag |
| rel_thr | input | 7 | Release level code |
| rel_x8 | input | 1 | Release level times-eight flag |
| up_rate | input | 6 | Upward tracking run length minus one |
| dn_rate | input | 6 | Downward tracking run length minus one |
| touch_deb | input | 4 | Touch debounce count N |
| rel_deb | input | 4 | Release debounce count M |
| touched | output | 1 | Debounced touch state |
| raw_touch | output | 1 | Per-sample touch judgement |
| drop | output | 10 | Saturated reference minus sample |

## Verification
The checker checks the following on every cycle:
- the reference stays frozen across touched samples;
- the reference never moves by more than one code per sample;
- the debounced state only flips on a sample whose judgement agrees with the new state;
- idle cycles hold every output;
- a raw touch never appears with a drop below both levels;
- the outputs stay cleared while the channel is disabled.

Some behaviours need the bench's scenarios and its reference model:
- the exact run lengths behind each tracking step;
- the seeding fractions;
- the times-eight scaling;
- the debounce counts;
- the refusal of configuration changes made while running.

// File: rtl/tdd_pkg.sv
// Shared widths, configuration record and arithmetic helpers for the
// drift-tracking touch detector. Assumes sample values are unsigned codes.
package tdd_pkg;
    parameter int TD_SAMPLE_W = 10;
    parameter int TD_THR_W    = 7;
    parameter int TD_SCALE_SH = 3;
    parameter int TD_RATE_W   = 6;
    parameter int TD_DEB_W    = 4;
    localparam int TD_WIDE_W  = TD_SAMPLE_W + 5;

    typedef logic [TD_SAMPLE_W-1:0] sample_t;
    typedef logic [TD_WIDE_W-1:0]   wide_t;
    typedef logic [TD_RATE_W-1:0]   rate_t;
    typedef logic [TD_DEB_W-1:0]    deb_t;

    typedef enum logic [1:0] {
        SEED_USER = 2'b00,
        SEED_FULL = 2'b01,
        SEED_31   = 2'b10,
        SEED_30   = 2'b11
    } seed_mode_e;

    typedef struct packed {
        seed_mode_e mode;
        sample_t    user_ref;
        sample_t    touch_lvl;
        sample_t    rel_lvl;
        rate_t      up_rate;
        rate_t      dn_rate;
        deb_t       touch_deb;
        deb_t       rel_deb;
    } cfg_t;

    // Expand a level code with its times-eight flag to sample width.
    function automatic sample_t scale_level(logic [TD_THR_W-1:0] code, logic x8);
        sample_t w;
        w = sample_t'(code);
        return x8 ? (w << TD_SCALE_SH) : w;
    endfunction

    // Initial reference for the chosen seed mode, fractions rounded down.
    function automatic sample_t seed_of(seed_mode_e m, sample_t s, sample_t u);
        wide_t ws;
        wide_t prod;
        ws = wide_t'(s);
        case (m)
            SEED_USER: prod = wide_t'(u) << 5;
            SEED_FULL: prod = ws << 5;
            SEED_31:   prod = ws * wide_t'(31);
            default:   prod = ws * wide_t'(30);
        endcase
        return sample_t'(prod >> 5);
    endfunction

    // Drop of the sample below the reference, clamped at zero.
    function automatic sample_t sat_drop(sample_t r, sample_t s);
        return (r > s) ? sample_t'(r - s) : '0;
    endfunction
endpackage

// File: rtl/tdd_cfg_capture.sv
// Configuration capture. Registers the setup fields every cycle while the
// channel is disabled and holds them while it runs. Assumes software only
// changes the setup between runs; changes during a run are dropped.
module tdd_cfg_capture
    import tdd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [1:0]          seed_mode,
    input  sample_t             user_ref,
    input  logic [TD_THR_W-1:0] touch_thr,
    input  logic                touch_x8,
    input  logic [TD_THR_W-1:0] rel_thr,
    input  logic                rel_x8,
    input  rate_t               up_rate,
    input  rate_t               dn_rate,
    input  deb_t                touch_deb,
    input  deb_t                rel_deb,
    output cfg_t                cfg_q
);
    cfg_t cfg_d;

    // Assemble the next record with the levels already scaled.
    always_comb begin
        cfg_d.mode      = seed_mode_e'(seed_mode);
        cfg_d.user_ref  = user_ref;
        cfg_d.touch_lvl = scale_level(touch_thr, touch_x8);
        cfg_d.rel_lvl   = scale_level(rel_thr, rel_x8);
        cfg_d.up_rate   = up_rate;
        cfg_d.dn_rate   = dn_rate;
        cfg_d.touch_deb = touch_deb;
        cfg_d.rel_deb   = rel_deb;
    end

    // Load while disabled, hold while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/tdd_judge.sv
// Per-sample judgement. Computes the saturated drop below the reference and
// the raw touch decision, with hysteresis picked by the debounced state.
// Purely combinational; assumes the reference is valid once seeded.
module tdd_judge
    import tdd_pkg::*;
(
    input  logic    seeded,
    input  logic    touched,
    input  sample_t ref_val,
    input  sample_t sample,
    input  sample_t touch_lvl,
    input  sample_t rel_lvl,
    output sample_t drop,
    output logic    raw
);
    // Compare against the level that belongs to the current state.
    always_comb begin
        drop = seeded ? sat_drop(ref_val, sample) : '0;
        if (!seeded) begin
            raw = 1'b0;
        end else if (touched) begin
            raw = (drop >= rel_lvl);
        end else begin
            raw = (drop >= touch_lvl);
        end
    end
endmodule

// File: rtl/tdd_ref_track.sv
// No-touch reference keeper. Seeds from the first sample after enable, then
// steps by one toward the measurement after a run of same-side samples whose
// length is set per direction. Frozen while the channel is touched.
module tdd_ref_track
    import tdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       step,
    input  sample_t    sample,
    input  logic       touched,
    input  seed_mode_e mode,
    input  sample_t    user_ref,
    input  rate_t      up_rate,
    input  rate_t      dn_rate,
    output sample_t    ref_q,
    output logic       seeded_q
);
    localparam int N_DIR = 2;   // 0: upward, 1: downward

    logic              side_hit [N_DIR];
    rate_t             run_lim  [N_DIR];
    logic [N_DIR-1:0]  fire;

    assign side_hit[0] = (sample > ref_q);
    assign side_hit[1] = (sample < ref_q);
    assign run_lim[0]  = up_rate;
    assign run_lim[1]  = dn_rate;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        rate_t run_q;
        logic  track;

        assign track   = step && seeded_q && !touched && side_hit[g];
        assign fire[g] = track && (run_q == run_lim[g]);

        // Count consecutive same-side released samples for this direction.
        always_ff @(posedge clk) begin
            if (!rst_n || !enable) begin
                run_q <= '0;
            end else if (step) begin
                if (!track || fire[g]) begin
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    // Seed on the first sample, then apply single-code tracking steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q    <= '0;
            seeded_q <= 1'b0;
        end else if (!enable) begin
            seeded_q <= 1'b0;
        end else if (step) begin
            if (!seeded_q) begin
                ref_q    <= seed_of(mode, sample, user_ref);
                seeded_q <= 1'b1;
            end else if (fire[0]) begin
                ref_q <= ref_q + 1'b1;
            end else if (fire[1]) begin
                ref_q <= ref_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdd_debounce.sv
// Debounced touch state. Flips only after a run of opposing judgements one
// longer than the count programmed for that direction. Assumes step is
// asserted once per judged sample.
module tdd_debounce
    import tdd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic step,
    input  logic raw,
    input  deb_t touch_deb,
    input  deb_t rel_deb,
    output logic touched_q
);
    deb_t cnt_q;
    logic opposing;
    deb_t need;

    assign opposing = (raw != touched_q);
    assign need     = touched_q ? rel_deb : touch_deb;

    // Track the opposing run and flip the state when it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            touched_q <= 1'b0;
            cnt_q     <= '0;
        end else if (step) begin
            if (!opposing) begin
                cnt_q <= '0;
            end else if (cnt_q == need) begin
                touched_q <= !touched_q;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/touch_drift_detector.sv
// Single-channel drift-tracking touch detector. Accepts one filtered sample
// per valid strobe, keeps a drifting no-touch reference, and reports the
// saturated drop, the raw judgement and the debounced touch state.
// Assumes configuration is changed only while enable is low.
module touch_drift_detector
    import tdd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   sample_valid,
    input  logic [TD_SAMPLE_W-1:0] sample,
    input  logic [1:0]             seed_mode,
    input  logic [TD_SAMPLE_W-1:0] user_ref,
    input  logic [TD_THR_W-1:0]    touch_thr,
    input  logic                   touch_x8,
    input  logic [TD_THR_W-1:0]    rel_thr,
    input  logic                   rel_x8,
    input  logic [TD_RATE_W-1:0]   up_rate,
    input  logic [TD_RATE_W-1:0]   dn_rate,
    input  logic [TD_DEB_W-1:0]    touch_deb,
    input  logic [TD_DEB_W-1:0]    rel_deb,
    output logic                   touched,
    output logic                   raw_touch,
    output logic [TD_SAMPLE_W-1:0] drop
);
    cfg_t    cfg_q;
    sample_t ref_q;
    logic    seeded_q;
    logic    step;
    sample_t drop_c;
    logic    raw_c;
    sample_t drop_q;
    logic    raw_q;

    assign step = enable && sample_valid;

    tdd_cfg_capture u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .seed_mode (seed_mode),
        .user_ref  (user_ref),
        .touch_thr (touch_thr),
        .touch_x8  (touch_x8),
        .rel_thr   (rel_thr),
        .rel_x8    (rel_x8),
        .up_rate   (up_rate),
        .dn_rate   (dn_rate),
        .touch_deb (touch_deb),
        .rel_deb   (rel_deb),
        .cfg_q     (cfg_q)
    );

    tdd_judge u_judge (
        .seeded    (seeded_q),
        .touched   (touched),
        .ref_val   (ref_q),
        .sample    (sample),
        .touch_lvl (cfg_q.touch_lvl),
        .rel_lvl   (cfg_q.rel_lvl),
        .drop      (drop_c),
        .raw       (raw_c)
    );

    tdd_ref_track u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .step     (step),
        .sample   (sample),
        .touched  (touched),
        .mode     (cfg_q.mode),
        .user_ref (cfg_q.user_ref),
        .up_rate  (cfg_q.up_rate),
        .dn_rate  (cfg_q.dn_rate),
        .ref_q    (ref_q),
        .seeded_q (seeded_q)
    );

    tdd_debounce u_deb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .step      (step && seeded_q),
        .raw       (raw_c),
        .touch_deb (cfg_q.touch_deb),
        .rel_deb   (cfg_q.rel_deb),
        .touched_q (touched)
    );

    // Register the per-sample drop and judgement on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            drop_q <= '0;
            raw_q  <= 1'b0;
        end else if (step) begin
            drop_q <= drop_c;
            raw_q  <= raw_c;
        end
    end

    assign drop      = drop_q;
    assign raw_touch = raw_q;
endmodule

// File: rtl/tdd_checker.sv
// Temporal checks for the touch detector, attached by bind.
module tdd_checker
    import tdd_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    enable,
    input logic    sample_valid,
    input logic    touched,
    input logic    raw_touch,
    input sample_t drop,
    input sample_t ref_q,
    input logic    seeded_q,
    input sample_t touch_lvl,
    input sample_t rel_lvl
);
    sample_t min_lvl;
    assign min_lvl = (touch_lvl < rel_lvl) ? touch_lvl : rel_lvl;

    // R3: reference unchanged across a sample taken in the touched state
    p_ref_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(touched) && $past(enable) && $past(seeded_q))
        |-> (ref_q == $past(ref_q)));

    // R4: tracking moves the reference by at most one code per cycle
    p_ref_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(seeded_q) && $past(enable))
        |-> ((ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1)
             || ($past(ref_q) == ref_q + 1'b1)));

    // R1 / R6: a raw touch needs a drop of at least the smaller level
    p_raw_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        raw_touch |-> (drop >= min_lvl));

    // R7: entering touched happens on a touch judgement
    p_rise_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(touched)) |-> raw_touch);

    // R7: leaving touched while running happens on a release judgement
    p_fall_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable) && $fell(touched)) |-> !raw_touch);

    // R10: a cycle without a strobe leaves the outputs alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable) && !$past(sample_valid))
        |-> ($stable(touched) && $stable(raw_touch) && $stable(drop)));

    // R9: a disabled channel reports nothing
    p_disabled_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable))
        |-> (!touched && !raw_touch && (drop == '0)));
endmodule

bind touch_drift_detector tdd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_valid (sample_valid),
    .touched      (touched),
    .raw_touch    (raw_touch),
    .drop         (drop),
    .ref_q        (ref_q),
    .seeded_q     (seeded_q),
    .touch_lvl    (cfg_q.touch_lvl),
    .rel_lvl      (cfg_q.rel_lvl)
);

// File: tb/touch_drift_detector_tb_top.sv
module touch_drift_detector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       sample_valid;
    logic [9:0] sample;
    logic [1:0] seed_mode;
    logic [9:0] user_ref;
    logic [6:0] touch_thr;
    logic       touch_x8;
    logic [6:0] rel_thr;
    logic       rel_x8;
    logic [5:0] up_rate;
    logic [5:0] dn_rate;
    logic [3:0] touch_deb;
    logic [3:0] rel_deb;
    logic       touched;
    logic       raw_touch;
    logic [9:0] drop;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state and captured setup
    int m_ref, m_up, m_dn, m_dcnt;
    bit m_seeded, m_touched;
    int c_mode, c_user, c_t, c_r, c_up, c_dn, c_td, c_rd;
    int e_drop;
    bit e_raw;

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_drift_detector dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
        .sample(sample), .seed_mode(seed_mode), .user_ref(user_ref),
        .touch_thr(touch_thr), .touch_x8(touch_x8), .rel_thr(rel_thr),
        .rel_x8(rel_x8), .up_rate(up_rate), .dn_rate(dn_rate),
        .touch_deb(touch_deb), .rel_deb(rel_deb), .touched(touched),
        .raw_touch(raw_touch), .drop(drop)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int r, input int s);
        return (r > s) ? r - s : 0;
    endfunction

    // Advance the model by one accepted sample following the requirements.
    task automatic model_step(input int s);
        int d;
        int need;
        if (!m_seeded) begin
            case (c_mode)
                0: m_ref = c_user;
                1: m_ref = s;
                2: m_ref = (s * 31) / 32;
                default: m_ref = (s * 30) / 32;
            endcase
            m_seeded = 1;
            e_drop = 0;
            e_raw = 0;
        end else begin
            d = sat(m_ref, s);
            e_drop = d;
            e_raw = m_touched ? (d >= c_r) : (d >= c_t);
            if (m_touched) begin
                m_up = 0; m_dn = 0;
            end else if (s > m_ref) begin
                m_dn = 0;
                if (m_up == c_up) begin m_ref++; m_up = 0; end else m_up++;
            end else if (s < m_ref) begin
                m_up = 0;
                if (m_dn == c_dn) begin m_ref--; m_dn = 0; end else m_dn++;
            end else begin
                m_up = 0; m_dn = 0;
            end
            if (e_raw != m_touched) begin
                need = m_touched ? c_rd : c_td;
                if (m_dcnt == need) begin m_touched = !m_touched; m_dcnt = 0; end
                else m_dcnt++;
            end else begin
                m_dcnt = 0;
            end
        end
    endtask

    // Disable, load a setup, capture it in the model, then enable.
    task automatic setup(input int mode, input int uref, input int tt, input bit tx8,
                         input int rt, input bit rx8, input int ur, input int dr,
                         input int td, input int rd);
        @(negedge clk);
        enable = 0;
        seed_mode = 2'(mode); user_ref = 10'(uref);
        touch_thr = 7'(tt); touch_x8 = tx8; rel_thr = 7'(rt); rel_x8 = rx8;
        up_rate = 6'(ur); dn_rate = 6'(dr); touch_deb = 4'(td); rel_deb = 4'(rd);
        @(negedge clk);
        @(negedge clk);
        c_mode = mode; c_user = uref;
        c_t = tx8 ? tt * 8 : tt; c_r = rx8 ? rt * 8 : rt;
        c_up = ur; c_dn = dr; c_td = td; c_rd = rd;
        m_seeded = 0; m_touched = 0; m_up = 0; m_dn = 0; m_dcnt = 0;
        enable = 1;
    endtask

    // Drive one sample, then compare all outputs with the model.
    task automatic send(input int s, input string req);
        @(negedge clk);
        sample = 10'(s);
        sample_valid = 1;
        model_step(s);
        @(negedge clk);
        sample_valid = 0;
        check({req, " drop"}, int'(drop), e_drop);
        check({req, " raw"}, int'(raw_touch), int'(e_raw));
        check({req, " touched"}, int'(touched), int'(m_touched));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        int s;
        int hold_drop;
        int hold_raw;
        int hold_t;
        void'($urandom(32'd4021));
        rst_n = 0; enable = 0; sample_valid = 0; sample = '0;
        seed_mode = '0; user_ref = '0; touch_thr = '0; touch_x8 = 0;
        rel_thr = '0; rel_x8 = 0; up_rate = '0; dn_rate = '0;
        touch_deb = '0; rel_deb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset and disabled state reads zero
        check("R9 reset touched", int'(touched), 0);
        check("R9 reset raw", int'(raw_touch), 0);
        check("R9 reset drop", int'(drop), 0);

        // R5: each seed mode, checked through the drop of the next sample
        setup(1, 0, 100, 0, 50, 0, 63, 63, 0, 0);
        send(640, "R5 seed full first");
        send(600, "R5 seed full");
        check("R5 seed full value", int'(drop), 40);
        setup(2, 0, 100, 0, 50, 0, 63, 63, 0, 0);
        send(640, "R5 seed 31/32 first");
        send(600, "R5 seed 31/32");
        check("R5 seed 31/32 value", int'(drop), 20);
        setup(3, 0, 100, 0, 50, 0, 63, 63, 0, 0);
        send(641, "R5 seed 30/32 first");
        send(580, "R5 seed 30/32");
        check("R5 seed 30/32 value", int'(drop), 20);
        setup(0, 700, 100, 0, 50, 0, 63, 63, 0, 0);
        send(300, "R5 seed user first");
        send(650, "R5 seed user");
        check("R5 seed user value", int'(drop), 50);

        // R2 / R1: times-eight touch level 5 -> 40, boundary at equality
        setup(1, 0, 5, 1, 2, 1, 63, 63, 0, 0);
        send(500, "R2 seed");
        send(461, "R2 drop 39");
        check("R1 below level raw", int'(raw_touch), 0);
        send(460, "R2 drop 40");
        check("R1 at level raw", int'(raw_touch), 1);
        // R6: release level 16, stays touched at 16, releases at 15
        send(484, "R6 drop 16");
        check("R6 at release level", int'(touched), 1);
        send(485, "R6 drop 15");
        check("R6 below release level", int'(touched), 0);
        // R8: sample above reference saturates
        send(520, "R8 saturate");
        check("R8 saturated drop", int'(drop), 0);

        // R7: touch count 3 flips on the fourth touch judgement
        setup(1, 0, 20, 0, 10, 0, 63, 63, 3, 2);
        send(500, "R7 seed");
        for (int i = 0; i < 3; i++) send(450, "R7 touch run");
        check("R7 not yet touched", int'(touched), 0);
        send(450, "R7 fourth");
        check("R7 touched on fourth", int'(touched), 1);
        // R3: deep touches must not drag the frozen reference
        for (int i = 0; i < 6; i++) send(300, "R3 frozen");
        check("R3 frozen drop", int'(drop), 200);
        for (int i = 0; i < 3; i++) send(500, "R7 release run");
        check("R7 released on third", int'(touched), 0);

        // R4: up-rate 2 steps after 3 samples above; down-rate 4 after 5 below
        setup(1, 0, 100, 0, 50, 0, 2, 4, 0, 0);
        send(500, "R4 seed");
        for (int i = 0; i < 3; i++) send(510, "R4 rise");
        send(490, "R4 probe up");
        check("R4 one step up", int'(drop), 11);
        for (int i = 0; i < 4; i++) send(490, "R4 fall");
        send(480, "R4 probe down");
        check("R4 one step down", int'(drop), 20);

        // R9: changes while running are ignored
        touch_thr = 7'd0; rel_thr = 7'd0; touch_deb = 4'd0;
        send(495, "R9 running change");
        check("R9 ignored level", int'(raw_touch), 0);
        // R10: idle cycles hold outputs
        hold_drop = int'(drop); hold_raw = int'(raw_touch); hold_t = int'(touched);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            sample = 10'($urandom_range(0, 1023));
        end
        check("R10 hold drop", int'(drop), hold_drop);
        check("R10 hold raw", int'(raw_touch), hold_raw);
        check("R10 hold touched", int'(touched), hold_t);
        send(470, "R10 after idle");

        // random runs against the model
        for (int k = 0; k < 4; k++) begin
            int tt;
            tt = $urandom_range(10, 60);
            setup($urandom_range(0, 3), $urandom_range(400, 700), tt, 0,
                  $urandom_range(3, tt), 0, $urandom_range(0, 7),
                  $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3));
            base = $urandom_range(450, 650);
            for (int i = 0; i < 300; i++) begin
                if ((i / 25) % 2 == 1)
                    s = base - $urandom_range(0, 150);
                else
                    s = base + $urandom_range(0, 8) - 4;
                if (i % 60 == 0) base = base + $urandom_range(0, 10) - 5;
                send(s, "R1 R4 R6 R7 random");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule